// File: doc/BRIEF.md
# DRAM refresh and initialization scheduler

This block runs beside the host-side memory controller of an asynchronous DRAM and decides when refresh cycles must be taken. After reset it holds off all traffic for a power-up settling time. It then requests a fixed burst of warm-up refreshes (eight by default). Only after that does it declare the memory ready. From then on a ticker adds one owed refresh per interval, sized so that every row is refreshed within the retention period. Each owed refresh is requested through a request/grant/done handshake with the cycle engine that drives the strobes.

Owed refreshes are counted, so a controller may postpone refreshes during heavy traffic and catch up later. The count saturates at a bound, and a sticky overflow flag records that a refresh was lost. Once the debt reaches an urgency level, the block withholds its permission for host accesses so that the refreshes win. In row-addressed mode the block supplies the row to refresh, taken from a wrapping row counter. In the self-addressed mode (CAS-before-RAS) no row is needed and the row output stays zero.

The controller is a state machine with six states:

| State | Meaning | Transition out |
|---|---|---|
| ST_POWERUP | Start-up wait | goes to ST_WARM_REQ when the start-up timer expires |
| ST_WARM_REQ | Warm-up refresh requested | goes to ST_WARM_BUSY on grant |
| ST_WARM_BUSY | Warm-up refresh running | on done, returns to ST_WARM_REQ, or goes to ST_IDLE after the last warm-up refresh |
| ST_IDLE | Normal operation, no debt | goes to ST_REQ when the owed count is nonzero |
| ST_REQ | Normal refresh requested | goes to ST_BUSY on grant |
| ST_BUSY | Normal refresh running | returns to ST_IDLE on done |

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and right after it, ref_req, ready, host_grant and overflow are 0, owed is 0 and ref_row is 0.
- R2: The first refresh request appears exactly STARTUP_CYCLES clock cycles after reset is released. Until then ref_req stays 0.
- R3: Exactly INIT_REFRESHES (default 8) warm-up refreshes are requested, each a grant followed by a done. ready rises on the clock edge that samples the last warm-up done. While ready is 0, host_grant is 0 whatever host_req does.
- R4: ref_req stays 1 from the moment it rises until the clock edge that samples ref_grant. It is 0 in the cycles after the grant, until ref_done.
- R5: Once ready, owed is incremented once every INTERVAL_CYCLES cycles. The first increment comes INTERVAL_CYCLES cycles after ready rises.
- R6: In normal operation each ref_done decrements owed. An increment and a done on the same edge leave owed unchanged. While owed is 0, ref_req is 0. A nonzero owed leads to a request one cycle later.
- R7: owed never exceeds OWED_MAX. An increment that would exceed it leaves owed at OWED_MAX and sets overflow. overflow then stays 1 until reset.
- R8: host_grant equals host_req when all of the following hold: ready is 1, no refresh is running, and owed is below URGENT_LEVEL. Otherwise host_grant is 0.
- R9: With RAS_ONLY=1, ref_with_row is 1. ref_row gives the row of the requested refresh, starting at 0. It increases by one after every completed refresh, warm-up ones included, and wraps from its all-ones value to 0. With RAS_ONLY=0, ref_with_row and ref_row are 0.
- R10: Once ready is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| host_req | input | 1 | Host controller wants to start an access |
| host_grant | output | 1 | Permission for the host access this cycle |
| ref_req | output | 1 | Refresh cycle requested |
| ref_grant | input | 1 | Cycle engine accepts the refresh request |
| ref_done | input | 1 | Cycle engine finished the granted refresh |
| ref_with_row | output | 1 | 1 when the refresh must drive ref_row (row-addressed mode) |
| ref_row | output | ROW_BITS | Row to refresh in row-addressed mode |
| ready | output | 1 | Start-up and warm-up complete, normal traffic allowed |
| owed | output | $clog2(OWED_MAX+1) | Refreshes currently owed |
| overflow | output | 1 | Sticky: a refresh was lost to saturation |

## Verification
Faults show up in different ways at the ports. A wrong state or warm-up count shows as a first request at the wrong cycle, or as ready rising after the wrong number of done pulses. Either is visible within one refresh handshake. A faulty debt counter diverges from a cycle-exact model of the interval ticks and done pulses. The divergence appears on the first tick after the fault, which is one interval at most. A row counter that skips or wraps wrongly is caught by the scoreboard on the very next grant. The warm-up sequence crosses the wrap point of the shortened row counter used by the bench. A lost urgency threshold shows as host_grant staying high while the debt is at or above the threshold.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_WARM_REQ,
        ST_WARM_BUSY,
        ST_IDLE,
        ST_REQ,
        ST_BUSY
    } sched_state_t;
endpackage

// File: rtl/ref_timer.sv
// Free-running period counter; restarts whenever disabled.
module ref_timer #(
    parameter int PERIOD = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!en)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

    generate
        if (PERIOD > 1) begin : g_gap
            // R5: two ticks are never adjacent
            a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ref_owed_ctr.sv
// Saturating owed-refresh counter with sticky overflow.
module ref_owed_ctr #(
    parameter int OWED_MAX = 8,
    localparam int W = $clog2(OWED_MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         overflow
);
    localparam logic [W-1:0] MAXV = W'(OWED_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            unique case ({inc, dec})
                2'b10: begin
                    if (count == MAXV) overflow <= 1'b1;
                    else               count    <= count + 1'b1;
                end
                2'b01: if (count != '0) count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= MAXV);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && count != '0) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/ref_row_ctr.sv
// Row pointer for row-addressed refresh; constant zero otherwise.
module ref_row_ctr #(
    parameter int ROW_BITS = 10,
    parameter bit RAS_ONLY = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] row,
    output logic                with_row
);
    generate
        if (RAS_ONLY) begin : g_row
            logic [ROW_BITS-1:0] row_q;
            always_ff @(posedge clk) begin
                if (!rst_n)    row_q <= '0;
                else if (step) row_q <= row_q + 1'b1;
            end
            assign row      = row_q;
            assign with_row = 1'b1;

            // R9: one step per completed refresh, natural wrap
            a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> row == $past(row) + 1'b1);
            a_r9_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !step |=> $stable(row));
        end else begin : g_cbr
            assign row      = '0;
            assign with_row = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int STARTUP_CYCLES  = 40000,
    parameter int INIT_REFRESHES  = 8,
    parameter int INTERVAL_CYCLES = 3120,
    parameter int ROW_BITS        = 10,
    parameter int OWED_MAX        = 8,
    parameter int URGENT_LEVEL    = 4,
    parameter bit RAS_ONLY        = 1'b1,
    localparam int OWED_W = $clog2(OWED_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    output logic                host_grant,
    output logic                ref_req,
    input  logic                ref_grant,
    input  logic                ref_done,
    output logic                ref_with_row,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                ready,
    output logic [OWED_W-1:0]   owed,
    output logic                overflow
);
    localparam int WARM_W = $clog2(INIT_REFRESHES + 1);
    localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(INIT_REFRESHES - 1);
    localparam logic [OWED_W-1:0] URGENT_V  = OWED_W'(URGENT_LEVEL);

    sched_state_t state, state_nx;
    logic [WARM_W-1:0] warm_cnt;
    logic startup_tick, interval_tick;
    logic row_step, owed_dec, urgent;

    ref_timer #(.PERIOD(STARTUP_CYCLES)) u_startup (
        .clk(clk), .rst_n(rst_n), .en(state == ST_POWERUP), .tick(startup_tick));

    ref_timer #(.PERIOD(INTERVAL_CYCLES)) u_interval (
        .clk(clk), .rst_n(rst_n), .en(ready), .tick(interval_tick));

    ref_owed_ctr #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk(clk), .rst_n(rst_n), .inc(interval_tick), .dec(owed_dec),
        .count(owed), .overflow(overflow));

    ref_row_ctr #(.ROW_BITS(ROW_BITS), .RAS_ONLY(RAS_ONLY)) u_row (
        .clk(clk), .rst_n(rst_n), .step(row_step),
        .row(ref_row), .with_row(ref_with_row));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_POWERUP;
            warm_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WARM_BUSY && ref_done) warm_cnt <= warm_cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWERUP:   if (startup_tick) state_nx = ST_WARM_REQ;
            ST_WARM_REQ:  if (ref_grant)    state_nx = ST_WARM_BUSY;
            ST_WARM_BUSY: if (ref_done)
                              state_nx = (warm_cnt == WARM_LAST) ? ST_IDLE : ST_WARM_REQ;
            ST_IDLE:      if (owed != '0)   state_nx = ST_REQ;
            ST_REQ:       if (ref_grant)    state_nx = ST_BUSY;
            ST_BUSY:      if (ref_done)     state_nx = ST_IDLE;
            default:                        state_nx = ST_POWERUP;
        endcase
    end

    // outputs
    always_comb begin
        ref_req  = 1'b0;
        ready    = 1'b0;
        row_step = 1'b0;
        owed_dec = 1'b0;
        unique case (state)
            ST_POWERUP:   ;
            ST_WARM_REQ:  ref_req = 1'b1;
            ST_WARM_BUSY: row_step = ref_done;
            ST_IDLE:      ready = 1'b1;
            ST_REQ: begin
                ready   = 1'b1;
                ref_req = 1'b1;
            end
            ST_BUSY: begin
                ready    = 1'b1;
                row_step = ref_done;
                owed_dec = ref_done;
            end
            default: ;
        endcase
        urgent     = owed >= URGENT_V;
        host_grant = host_req && ready && (state != ST_BUSY) && !urgent;
    end

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_grant) |=> ref_req);
    a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant) |=> !ref_req);
    a_r3_no_host_early: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !host_grant);
    a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    a_r8_urgent_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (owed >= URGENT_V) |-> !host_grant);
    a_r6_no_req_without_debt: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && owed == '0) |-> !ref_req);
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int STARTUP  = 20;
    localparam int INIT     = 8;
    localparam int INTERVAL = 30;
    localparam int ROWB     = 3;
    localparam int OMAX     = 4;
    localparam int URG      = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, ref_grant = 1'b0, ref_done = 1'b0;
    logic host_grant, ref_req, ref_with_row, ready, overflow;
    logic [ROWB-1:0] ref_row;
    logic [2:0] owed;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .STARTUP_CYCLES(STARTUP), .INIT_REFRESHES(INIT), .INTERVAL_CYCLES(INTERVAL),
        .ROW_BITS(ROWB), .OWED_MAX(OMAX), .URGENT_LEVEL(URG), .RAS_ONLY(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_grant(host_grant),
        .ref_req(ref_req), .ref_grant(ref_grant), .ref_done(ref_done),
        .ref_with_row(ref_with_row), .ref_row(ref_row), .ready(ready),
        .owed(owed), .overflow(overflow));

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // scoreboard: expected rows pushed by driver, popped at each grant
    int exp_q[$];
    int m_row = 0;
    always @(negedge clk) begin
        if (rst_n && ref_grant && ref_req) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected grant", 0, 1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(ref_row) == e, "R9 refresh row", int'(ref_row), e);
                chk(ref_with_row == 1'b1, "R9 row-addressed flag", int'(ref_with_row), 1);
            end
        end
    end

    // owed model (R5, R6, R7)
    int cyc = 0, p_cyc = 0, m_owed = 0;
    bit m_ovf = 1'b0, model_on = 1'b0;
    always @(posedge clk) begin
        bit t;
        cyc++;
        if (model_on) begin
            t = ((cyc - p_cyc) % INTERVAL) == 0;
            if (t && !ref_done) begin
                if (m_owed == OMAX) m_ovf = 1'b1;
                else m_owed++;
            end else if (!t && ref_done && m_owed > 0) m_owed--;
        end
    end
    always @(negedge clk) begin
        if (model_on) begin
            chk(int'(owed) == m_owed, "R5/R6 owed vs model", int'(owed), m_owed);
            chk(overflow == m_ovf, "R7 overflow vs model", int'(overflow), int'(m_ovf));
        end
    end

    // driver: one full refresh handshake, starting at a negedge with ref_req high
    task automatic serve(input int hold, input bit warm);
        chk(ref_req == 1'b1, "R4 request present", int'(ref_req), 1);
        if (warm) chk(!ready && !host_grant, "R3 no host before ready",
                      int'({ready, host_grant}), 0);
        repeat (hold) begin
            @(negedge clk);
            chk(ref_req == 1'b1, "R4 request held until grant", int'(ref_req), 1);
        end
        exp_q.push_back(m_row);
        @(posedge clk); #1 ref_grant = 1'b1;
        @(posedge clk); #1 ref_grant = 1'b0;
        @(negedge clk);
        chk(!ref_req && !host_grant, "R4/R8 quiet while refresh runs",
            int'({ref_req, host_grant}), 0);
        @(posedge clk); #1 ref_done = 1'b1;
        @(posedge clk); #1 ref_done = 1'b0;
        m_row = (m_row + 1) % (1 << ROWB);
        @(negedge clk);
    endtask

    initial begin
        int n;
        host_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ref_req && !ready && !host_grant && !overflow && owed == 0 && ref_row == 0,
            "R1 reset state", int'({ref_req, ready, host_grant, overflow}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!ref_req && !ready && owed == 0, "R1 state after release",
            int'({ref_req, ready}), 0);
        n = 0;
        while (!ref_req && n < 1000) begin n++; @(negedge clk); end
        chk(n == STARTUP, "R2 start-up wait length", n, STARTUP);

        for (int i = 0; i < INIT; i++) begin
            serve((i == 0) ? 3 : 0, 1'b1);
            if (i < INIT - 1) chk(!ready, "R3 not ready before last warm-up",
                                  int'(ready), 0);
        end
        chk(ready == 1'b1, "R3 ready after last warm-up", int'(ready), 1);
        chk(ref_row == 0, "R9 row wrapped after warm-up", int'(ref_row), 0);
        chk(host_grant == 1'b1, "R8 host allowed with no debt", int'(host_grant), 1);
        p_cyc = cyc; m_owed = 0; m_ovf = 1'b0; model_on = 1'b1;

        n = 0;
        while (owed == 0 && n < 1000) begin n++; @(negedge clk); end
        chk(n == INTERVAL, "R5 first interval", n, INTERVAL);
        chk(host_grant == 1'b1 && ref_req == 1'b0, "R8 host allowed below threshold",
            int'({host_grant, ref_req}), 2);
        @(negedge clk);
        chk(ref_req == 1'b1, "R6 request follows debt", int'(ref_req), 1);

        n = 0;
        while (owed < URG && n < 1000) begin n++; @(negedge clk); end
        chk(host_grant == 1'b0 && ref_req == 1'b1, "R8 refresh wins at threshold",
            int'({host_grant, ref_req}), 1);
        n = 0;
        while (owed < OMAX && n < 1000) begin n++; @(negedge clk); end
        chk(overflow == 1'b0, "R7 no overflow at bound", int'(overflow), 0);
        repeat (INTERVAL + 1) @(negedge clk);
        chk(owed == OMAX && overflow == 1'b1, "R7 saturate and flag",
            int'(owed) * 2 + int'(overflow), OMAX * 2 + 1);
        chk(ready == 1'b1, "R10 ready stays high", int'(ready), 1);

        n = 0;
        while (owed != 0 && n < 400) begin
            n++;
            if (ref_req) serve(0, 1'b0);
            else @(negedge clk);
        end
        chk(owed == 0 && ref_req == 1'b0, "R6 catch-up clears debt and request",
            int'(owed) * 2 + int'(ref_req), 0);
        chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
        chk(host_grant == 1'b1, "R8 host allowed after catch-up", int'(host_grant), 1);
        chk(exp_q.size() == 0, "R9 every expected refresh granted", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule